// File: doc/BRIEF.md
# Wrapping-Pointer Register Stack

This block is a last-in, first-out store built from a bank of registers. It holds up to 64 words of a configurable width. A single pointer, as wide as the address, selects the top word. The pointer advances before each store and steps back after each fetch. Its arithmetic wraps at the depth, so the first word stored sits at address 1 and the last one that fits sits at address 0.

The two flags are not computed from an occupancy count. A flag is raised when the pointer lands on zero. It is the full flag when the pointer got there by advancing, and the empty flag when it got there by stepping back. Because of this rule no slot has to be sacrificed to tell full from empty.

The block is driven by single-cycle push and pop strobes. A fetched word appears in a registered output and stays there until the next fetch that is accepted. Requests that would overflow or underflow the stack are dropped silently.

Top module: `lifo_regstack`

## Requirements
- R1: While reset is held and on the first cycle after it, `empty_o` = 1, `full_o` = 0 and `dout_o` = 0.
- R2: Words come back from accepted pops in the reverse order of the accepted pushes that stored them.
- R3: An accepted push (`push_i` = 1 while `full_o` = 0) clears `empty_o` at the next clock edge. It sets `full_o` only when that push brings the stack to 64 stored words.
- R4: An accepted pop (`pop_i` = 1, `push_i` = 0, `empty_o` = 0) loads the top word into `dout_o`, which is visible after the same clock edge.
- R5: An accepted pop clears `full_o`. It sets `empty_o` only when it removes the last stored word.
- R6: A push while `full_o` = 1 is ignored: the flags and the stored words are unchanged, so the following pops return the earlier contents.
- R7: A pop while `empty_o` = 1 is ignored: `dout_o` and both flags keep their values.
- R8: When `push_i` and `pop_i` are both 1 in a cycle, the push is performed and the pop is dropped, so `dout_o` holds. If the stack is full in that cycle, neither request has any effect.
- R9: `dout_o` changes only on an accepted pop and otherwise holds its last value.
- R10: All 64 locations are usable: `full_o` stays 0 after 63 pushes from empty, becomes 1 after the 64th, and all 64 words are returned intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push strobe, one word per cycle |
| pop_i | input | 1 | Pop strobe, one word per cycle |
| din_i | input | DATA_W | Word to store on a push |
| dout_o | output | DATA_W | Registered word read by the latest accepted pop |
| full_o | output | 1 | Stack holds 64 words |
| empty_o | output | 1 | Stack holds no words |

## Verification
A push and a pop can be requested in the same cycle. The push wins, and when the stack is full the colliding pair is dropped entirely. The bench raises both strobes together in directed steps: from an empty stack, from a partly filled stack and from a full one. The random phase also sets the two strobes independently, so collisions fall at arbitrary depths. Each such cycle is judged by a count-based reference model: the flags must follow the push alone, `dout_o` must hold, and the next pops must return the colliding push's word first.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

    // Push wins over pop; a request against a full or empty stack is dropped.
    function automatic stk_op_e pick_op(input logic push, input logic pop,
                                        input logic full, input logic empty);
        stk_op_e op;
        op = STK_IDLE;
        if (push) begin
            if (!full) op = STK_PUSH;
        end else if (pop && !empty) begin
            op = STK_POP;
        end
        return op;
    endfunction

endpackage

// File: rtl/lifo_sp_ctrl.sv
module lifo_sp_ctrl
    import lifo_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              full_o,
    output logic              empty_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] sp;
        logic              full;
        logic              empty;
    } ptr_state_t;

    ptr_state_t state_d, state_q;
    logic [ADDR_W-1:0] sp_inc, sp_dec;

    always_comb begin
        sp_inc  = state_q.sp + ADDR_W'(1);
        sp_dec  = state_q.sp - ADDR_W'(1);
        state_d = state_q;
        case (op_i)
            STK_PUSH: begin
                state_d.sp    = sp_inc;
                state_d.full  = (sp_inc == '0);
                state_d.empty = 1'b0;
            end
            STK_POP: begin
                state_d.sp    = sp_dec;
                state_d.empty = (sp_dec == '0);
                state_d.full  = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.sp    <= '0;
            state_q.full  <= 1'b0;
            state_q.empty <= 1'b1;
        end else begin
            state_q <= state_d;
        end
    end

    assign sp_o      = state_q.sp;
    assign wr_addr_o = sp_inc;
    assign full_o    = state_q.full;
    assign empty_o   = state_q.empty;

    // R3
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));

    // R10
    flag_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o || empty_o) |-> (sp_o == '0));

    // R3
    push_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_PUSH) |=> (sp_o == ADDR_W'($past(sp_o) + ADDR_W'(1))) && !empty_o);

    // R5
    pop_retreat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_POP) |=> (sp_o == ADDR_W'($past(sp_o) - ADDR_W'(1))) && !full_o);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == STK_IDLE) |=> $stable(sp_o) && $stable(full_o) && $stable(empty_o));

endmodule

// File: rtl/lifo_regfile.sv
module lifo_regfile #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] row_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [DATA_W-1:0] row_d;

        always_comb begin
            row_d = row_q[g];
            if (we_i && (waddr_i == ADDR_W'(g))) row_d = wdata_i;
        end

        always_ff @(posedge clk) begin
            row_q[g] <= row_d;
        end
    end

    assign rdata_o = row_q[raddr_i];

endmodule

// File: rtl/lifo_regstack.sv
module lifo_regstack
    import lifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [DATA_W-1:0] dout_o,
    output logic              full_o,
    output logic              empty_o
);

    stk_op_e           op;
    logic [ADDR_W-1:0] sp, wr_addr;
    logic [DATA_W-1:0] top_word;
    logic [DATA_W-1:0] dout_d, dout_q;

    assign op = pick_op(push_i, pop_i, full_o, empty_o);

    lifo_sp_ctrl #(.ADDR_W(ADDR_W)) i_sp_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .sp_o      (sp),
        .wr_addr_o (wr_addr),
        .full_o    (full_o),
        .empty_o   (empty_o)
    );

    lifo_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regfile (
        .clk     (clk),
        .we_i    (op == STK_PUSH),
        .waddr_i (wr_addr),
        .wdata_i (din_i),
        .raddr_i (sp),
        .rdata_o (top_word)
    );

    always_comb begin
        dout_d = dout_q;
        if (op == STK_POP) dout_d = top_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else        dout_q <= dout_d;
    end

    assign dout_o = dout_q;

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop_i && !push_i && !empty_o) |=> $stable(dout_o));

    // R7
    underflow_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> empty_o && !full_o && $stable(dout_o));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> full_o && !empty_o);

    // R8
    push_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !full_o) |=> !empty_o && $stable(dout_o));

endmodule

// File: tb/test_lifo_regstack.sv
module test_lifo_regstack;

    localparam int DW    = 16;
    localparam int DEPTH = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push = 1'b0, pop = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          full, empty;

    logic [DW-1:0] mdl [DEPTH];
    int            mcnt = 0;
    logic [DW-1:0] mdout = '0;
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    lifo_regstack #(.DATA_W(DW), .ADDR_W(6)) i_lifo_regstack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .din_i(din), .dout_o(dout), .full_o(full), .empty_o(empty)
    );

    function automatic bit exp_full(input int cnt);
        return cnt == DEPTH;
    endfunction

    function automatic bit exp_empty(input int cnt);
        return cnt == 0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, model the edge, sample 1 ns after posedge.
    task automatic step(input bit p, input bit q, input logic [DW-1:0] d,
                        input string ftag, input string dtag);
        @(negedge clk);
        push = p; pop = q; din = d;
        @(posedge clk);
        #1;
        if (p) begin
            if (mcnt < DEPTH) begin
                mdl[mcnt] = d;
                mcnt++;
            end
        end else if (q && mcnt > 0) begin
            mcnt--;
            mdout = mdl[mcnt];
        end
        push = 1'b0; pop = 1'b0;
        chk(ftag, {30'd0, full, empty}, {30'd0, exp_full(mcnt), exp_empty(mcnt)});
        chk(dtag, 32'(dout), 32'(mdout));
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));

        repeat (3) @(posedge clk);
        #1;
        // R1 during reset
        chk("R1", {30'd0, full, empty}, 32'd1);
        chk("R1", 32'(dout), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        // R1 first cycle after reset
        chk("R1", {30'd0, full, empty}, 32'd1);

        // R7: pop on empty ignored
        step(1'b0, 1'b1, '0, "R7", "R7");
        // R8: collision on empty stack performs the push
        step(1'b1, 1'b1, 16'hA5A5, "R8", "R8");
        step(1'b0, 1'b1, '0, "R4", "R4");
        step(1'b0, 1'b1, '0, "R5", "R7");

        // R10: fill 64, full only after the last one
        for (int i = 0; i < DEPTH; i++)
            step(1'b1, 1'b0, DW'(16'h1000 + i), (i == DEPTH - 1) ? "R10" : "R3", "R9");
        // R6: push on full ignored, also with pop asserted (R8)
        step(1'b1, 1'b0, 16'hDEAD, "R6", "R9");
        step(1'b1, 1'b1, 16'hBEEF, "R8", "R8");
        // R2 / R10: drain in reverse order
        for (int i = 0; i < DEPTH; i++)
            step(1'b0, 1'b1, '0, (i == DEPTH - 1) ? "R5" : "R2", "R2");
        step(1'b0, 1'b1, '0, "R7", "R7");

        // Partly filled collision then drain (R8, R2)
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, DW'(16'h2200 + i), "R3", "R9");
        step(1'b1, 1'b1, 16'h3333, "R8", "R8");
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, '0, "R5", "R2");

        // Random phase with biased bursts to reach both ends
        for (int blk = 0; blk < 24; blk++) begin
            int bias;
            bias = (blk % 2 == 0) ? 75 : 25;
            for (int i = 0; i < 150; i++) begin
                bit p, q;
                p = ($urandom % 100) < bias;
                q = ($urandom % 100) < (100 - bias);
                step(p, q, DW'($urandom), p ? "R3" : "R5", q ? "R4" : "R9");
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule